// File: doc/BRIEF.md
# Nonvolatile Memory Access Control Register

This block is one byte-wide control register in a small configuration register map, together with the logic that uses its value to guard an on-chip nonvolatile array. The byte holds three fields: an activation code, a write-permission code and a test selector. The activation code turns on the array's regulator. A startup timer then holds off all access until the array is ready. The write-permission code chooses between no writes, single-location writes, and a block write that floods the whole array with one byte.

The host writes the register over a simple register bus and then issues one-cycle read or write requests. An accepted request becomes a one-cycle array command on the next clock. A refused request becomes a one-cycle error pulse and no command. A block write holds the array write strobe high and walks the address from 0 to the last location, stepping once per array acknowledge. This also overwrites the locations that hold trim values. Deactivating the array aborts a block write that is in progress.

Top module: `nvm_access_top`

## Requirements
- R1: After reset the register reads 0x00, the regulator enable, ready flag, busy flag, error pulse, array read and array write are all low, and the test selector is 0.
- R2: A register-bus write with `regAddr` equal to `CTRL_ADDR` stores the whole byte. `regRdata` shows the stored byte exactly, including unrecognised codes, whenever `regAddr` equals `CTRL_ADDR`, and shows 0x00 otherwise. Writes to other addresses leave the register unchanged.
- R3: `regulatorEn` is high exactly when bits 2:0 of the register hold 3'b010 or 3'b101. Every other code turns it off.
- R4: `memReady` rises `STARTUP_CYCLES` clocks after the write edge that made the array active. A write that deactivates the array, or that changes the activation code, clears the flag at that edge and restarts the count. Rewriting the same active code does not restart the count.
- R5: A read request that is accepted produces `arrRd` high for one cycle on the next clock, with `arrAddr` equal to the requested address. A read is accepted when the array is ready, no block write is running, and no write is requested in the same cycle.
- R6: Bits 4:3 of the register select write permission: 2'b01 allows single writes and 2'b10 allows block write. With 2'b01, an accepted write request produces `arrWr` for one cycle on the next clock, carrying the requested address and data. With 2'b00 or 2'b11, write requests are refused.
- R7: A refused request produces `accessErr` high for exactly one cycle on the next clock and no array command. A request is refused when the array is not ready, a block write is running, both requests are raised together, or a write is requested without write permission.
- R8: With bits 4:3 at 2'b10, an accepted write request starts a block write on the next clock. `blockBusy` and `arrWr` stay high and `arrWdata` holds the supplied byte. `arrAddr` starts at 0 and advances by one on each cycle with `arrAck`. The cycle that acknowledges address `DEPTH-1` ends the block write at that edge.
- R9: A register write that clears the ready flag also ends a running block write at the same edge, dropping `blockBusy` and `arrWr`.
- R10: Bits 7:5 are forwarded unchanged on `testSel`, and `testActive` is high when they are nonzero. The test selector has no effect on activation, readiness or access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | REG_AW | Register-bus address |
| regWdata | input | 8 | Register-bus write data |
| regWe | input | 1 | Register-bus write strobe |
| regRdata | output | 8 | Register-bus read data |
| memRdReq | input | 1 | Host read request, one cycle |
| memWrReq | input | 1 | Host write request, one cycle |
| memAddr | input | AW | Requested array address |
| memWdata | input | 8 | Requested write data |
| arrAck | input | 1 | Array acknowledge for block-write steps |
| arrRd | output | 1 | Array read command |
| arrWr | output | 1 | Array write command |
| arrAddr | output | AW | Array command address |
| arrWdata | output | 8 | Array write data |
| regulatorEn | output | 1 | Enable for the array regulator |
| memReady | output | 1 | Startup delay has elapsed |
| blockBusy | output | 1 | Block write in progress |
| accessErr | output | 1 | Refused-request pulse |
| testSel | output | 3 | Forwarded test selector |
| testActive | output | 1 | Test selector is nonzero |

## Verification
The bound checker enforces several relations on every cycle. It confirms that readiness never appears with the regulator off and that no array command is issued while the array is not ready. It also confirms that read and write commands never overlap, that a block write always drives the write strobe, and that the block address steps by one after each acknowledge. The exact startup latency cannot be shown by these per-cycle relations, and neither can restart versus no restart on a rewrite of the activation code, the refusal rules for each write-permission code, or the abort of a block write. Only the bench's scenarios show these, by comparing against a behavioural model clock by clock.

// File: rtl/nvm_access_pkg.sv
package nvm_access_pkg;
  localparam logic [2:0] ACT_CODE_A = 3'b010;
  localparam logic [2:0] ACT_CODE_B = 3'b101;
  localparam logic [1:0] WE_SINGLE  = 2'b01;
  localparam logic [1:0] WE_FLOOD   = 2'b10;

  typedef struct packed {
    logic singleRd;
    logic singleWr;
    logic startBlock;
    logic reject;
    logic abort;
  } nvmStrobe_t;

  function automatic logic isActCode(input logic [2:0] code);
    return (code == ACT_CODE_A) || (code == ACT_CODE_B);
  endfunction
endpackage

// File: rtl/nvm_access_ctrl.sv
module nvm_access_ctrl
  import nvm_access_pkg::*;
#(
  parameter int REG_AW = 8,
  parameter logic [REG_AW-1:0] CTRL_ADDR = 8'h2C,
  parameter int STARTUP_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [7:0]        regWdata,
  input  logic              regWe,
  input  logic              memRdReq,
  input  logic              memWrReq,
  input  logic              busy,
  output logic [7:0]        ctrlByte,
  output logic              readyFlag,
  output nvmStrobe_t        strobe
);
  localparam int CW = $clog2(STARTUP_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(STARTUP_CYCLES - 1);

  logic [7:0]    ctrlQ;
  logic [CW-1:0] cntQ;
  logic          readyQ;
  logic          wrHit;
  logic [7:0]    nextByte;
  logic          nextAct;
  logic          clearNow;
  logic          readyOk;
  logic          anyReq;
  logic          permitWr;
  logic          accept;

  assign wrHit    = regWe && (regAddr == CTRL_ADDR);
  assign nextByte = wrHit ? regWdata : ctrlQ;
  assign nextAct  = isActCode(nextByte[2:0]);
  assign clearNow = !nextAct || (nextByte[2:0] != ctrlQ[2:0]);
  assign readyOk  = readyQ && !clearNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ  <= '0;
      cntQ   <= '0;
      readyQ <= 1'b0;
    end else begin
      ctrlQ <= nextByte;
      if (clearNow) begin
        cntQ   <= '0;
        readyQ <= 1'b0;
      end else if (!readyQ) begin
        if (cntQ == CNT_LAST) readyQ <= 1'b1;
        else cntQ <= cntQ + 1'b1;
      end
    end
  end

  assign anyReq   = memRdReq || memWrReq;
  assign permitWr = (ctrlQ[4:3] == WE_SINGLE) || (ctrlQ[4:3] == WE_FLOOD);
  assign accept   = anyReq && readyOk && !busy && !(memRdReq && memWrReq)
                    && (memRdReq || permitWr);

  always_comb begin
    strobe            = '0;
    strobe.reject     = anyReq && !accept;
    strobe.singleRd   = accept && memRdReq;
    strobe.singleWr   = accept && memWrReq && (ctrlQ[4:3] == WE_SINGLE);
    strobe.startBlock = accept && memWrReq && (ctrlQ[4:3] == WE_FLOOD);
    strobe.abort      = !readyOk;
  end

  assign ctrlByte  = ctrlQ;
  assign readyFlag = readyQ;
endmodule

// File: rtl/nvm_access_dp.sv
module nvm_access_dp
  import nvm_access_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  nvmStrobe_t    strobe,
  input  logic [AW-1:0] memAddr,
  input  logic [7:0]    memWdata,
  input  logic          arrAck,
  output logic          arrRd,
  output logic          arrWr,
  output logic [AW-1:0] arrAddr,
  output logic [7:0]    arrWdata,
  output logic          busy,
  output logic          errPulse
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  logic          rdQ, wrQ, busyQ, errQ;
  logic [AW-1:0] addrQ;
  logic [7:0]    dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQ   <= 1'b0;
      wrQ   <= 1'b0;
      busyQ <= 1'b0;
      errQ  <= 1'b0;
      addrQ <= '0;
      dataQ <= '0;
    end else begin
      rdQ  <= 1'b0;
      errQ <= strobe.reject;
      if (busyQ) begin
        if (strobe.abort) begin
          busyQ <= 1'b0;
          wrQ   <= 1'b0;
        end else if (arrAck) begin
          if (addrQ == LAST_ADDR) begin
            busyQ <= 1'b0;
            wrQ   <= 1'b0;
          end else begin
            addrQ <= addrQ + 1'b1;
          end
        end
      end else begin
        wrQ <= 1'b0;
        if (strobe.startBlock) begin
          busyQ <= 1'b1;
          wrQ   <= 1'b1;
          addrQ <= '0;
          dataQ <= memWdata;
        end else if (strobe.singleWr) begin
          wrQ   <= 1'b1;
          addrQ <= memAddr;
          dataQ <= memWdata;
        end else if (strobe.singleRd) begin
          rdQ   <= 1'b1;
          addrQ <= memAddr;
        end
      end
    end
  end

  assign arrRd    = rdQ;
  assign arrWr    = wrQ;
  assign arrAddr  = addrQ;
  assign arrWdata = dataQ;
  assign busy     = busyQ;
  assign errPulse = errQ;
endmodule

// File: rtl/nvm_access_top.sv
module nvm_access_top
  import nvm_access_pkg::*;
#(
  parameter int REG_AW = 8,
  parameter logic [REG_AW-1:0] CTRL_ADDR = 8'h2C,
  parameter int STARTUP_CYCLES = 2000,
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [7:0]        regWdata,
  input  logic              regWe,
  output logic [7:0]        regRdata,
  input  logic              memRdReq,
  input  logic              memWrReq,
  input  logic [AW-1:0]     memAddr,
  input  logic [7:0]        memWdata,
  input  logic              arrAck,
  output logic              arrRd,
  output logic              arrWr,
  output logic [AW-1:0]     arrAddr,
  output logic [7:0]        arrWdata,
  output logic              regulatorEn,
  output logic              memReady,
  output logic              blockBusy,
  output logic              accessErr,
  output logic [2:0]        testSel,
  output logic              testActive
);
  nvmStrobe_t strobe;
  logic [7:0] ctrlByte;
  logic       busy;

  nvm_access_ctrl #(
    .REG_AW(REG_AW), .CTRL_ADDR(CTRL_ADDR), .STARTUP_CYCLES(STARTUP_CYCLES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe),
    .memRdReq(memRdReq), .memWrReq(memWrReq), .busy(busy),
    .ctrlByte(ctrlByte), .readyFlag(memReady), .strobe(strobe)
  );

  nvm_access_dp #(.DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memAddr(memAddr), .memWdata(memWdata),
    .arrAck(arrAck), .arrRd(arrRd), .arrWr(arrWr), .arrAddr(arrAddr),
    .arrWdata(arrWdata), .busy(busy), .errPulse(accessErr)
  );

  assign regRdata    = (regAddr == CTRL_ADDR) ? ctrlByte : 8'h00;
  assign regulatorEn = isActCode(ctrlByte[2:0]);
  assign blockBusy   = busy;
  assign testSel     = ctrlByte[7:5];
  assign testActive  = |ctrlByte[7:5];
endmodule

// File: rtl/nvm_access_chk.sv
module nvm_access_chk #(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          regulatorEn,
  input logic          memReady,
  input logic          arrRd,
  input logic          arrWr,
  input logic          arrAck,
  input logic [AW-1:0] arrAddr,
  input logic          blockBusy
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  AST_READY_NEEDS_REG: assert property (@(posedge clk) disable iff (!rstN)
    !regulatorEn |-> !memReady); // R4
  AST_CMD_ONLY_READY: assert property (@(posedge clk) disable iff (!rstN)
    (arrRd || arrWr) |-> memReady); // R7
  AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(arrRd && arrWr)); // R5
  AST_BUSY_DRIVES_WR: assert property (@(posedge clk) disable iff (!rstN)
    blockBusy |-> arrWr); // R8
  AST_BLOCK_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (blockBusy && arrAck && arrAddr != LAST_ADDR) |=>
      (!blockBusy || arrAddr == $past(arrAddr) + AW'(1))); // R8
endmodule

bind nvm_access_top nvm_access_chk #(.DEPTH(DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .regulatorEn(regulatorEn), .memReady(memReady),
  .arrRd(arrRd), .arrWr(arrWr), .arrAck(arrAck), .arrAddr(arrAddr),
  .blockBusy(blockBusy)
);

// File: tb/sim_nvm_access_top.sv
module sim_nvm_access_top;
  localparam int CLK_PERIOD = 10;
  localparam int STARTUP = 12;
  localparam int DEPTH = 16;
  localparam int AW = 4;
  localparam logic [7:0] CADDR = 8'h2C;

  logic clk = 0, rstN = 0;
  logic [7:0] regAddr = 0, regWdata = 0;
  logic regWe = 0, memRdReq = 0, memWrReq = 0, arrAck = 0;
  logic [AW-1:0] memAddr = 0;
  logic [7:0] memWdata = 0;
  logic [7:0] regRdata, arrWdata;
  logic arrRd, arrWr, regulatorEn, memReady, blockBusy, accessErr, testActive;
  logic [AW-1:0] arrAddr;
  logic [2:0] testSel;

  int checks = 0, failures = 0, cycleNo = 0;
  bit ackOn = 0;

  nvm_access_top #(.CTRL_ADDR(CADDR), .STARTUP_CYCLES(STARTUP), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe),
    .regRdata(regRdata), .memRdReq(memRdReq), .memWrReq(memWrReq), .memAddr(memAddr),
    .memWdata(memWdata), .arrAck(arrAck), .arrRd(arrRd), .arrWr(arrWr),
    .arrAddr(arrAddr), .arrWdata(arrWdata), .regulatorEn(regulatorEn),
    .memReady(memReady), .blockBusy(blockBusy), .accessErr(accessErr),
    .testSel(testSel), .testActive(testActive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  int mReg = 0, mCnt = 0, mAddr = 0, mData = 0;
  bit mReady = 0, mBusy = 0, mRd = 0, mWr = 0, mErr = 0;

  function automatic bit actOk(int b);
    return ((b & 7) == 2) || ((b & 7) == 5);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int nReg, ewe;
    bit clr, ok, req, acc;
    cycleNo++;
    if (!rstN) begin
      mReg = 0; mCnt = 0; mAddr = 0; mData = 0;
      mReady = 0; mBusy = 0; mRd = 0; mWr = 0; mErr = 0;
    end else begin
      nReg = (regWe && regAddr == CADDR) ? int'(regWdata) : mReg;
      clr  = !actOk(nReg) || ((nReg & 7) != (mReg & 7));
      ok   = mReady && !clr;
      ewe  = (mReg >> 3) & 3;
      req  = memRdReq || memWrReq;
      acc  = req && ok && !mBusy && !(memRdReq && memWrReq) &&
             (memRdReq || ewe == 1 || ewe == 2);
      mErr = req && !acc;
      mRd  = 0;
      if (mBusy) begin
        if (!ok) begin mBusy = 0; mWr = 0; end
        else if (arrAck) begin
          if (mAddr == DEPTH-1) begin mBusy = 0; mWr = 0; end
          else mAddr++;
        end
      end else begin
        mWr = 0;
        if (acc && memWrReq && ewe == 2) begin
          mBusy = 1; mWr = 1; mAddr = 0; mData = memWdata;
        end else if (acc && memWrReq) begin
          mWr = 1; mAddr = memAddr; mData = memWdata;
        end else if (acc) begin
          mRd = 1; mAddr = memAddr;
        end
      end
      if (clr) begin mCnt = 0; mReady = 0; end
      else if (!mReady) begin
        if (mCnt == STARTUP-1) mReady = 1; else mCnt++;
      end
      mReg = nReg;
    end
    #2;
    if (rstN) begin
      check("R2 regRdata", regRdata, (regAddr == CADDR) ? mReg : 0);
      check("R3 regulatorEn", regulatorEn, actOk(mReg));
      check("R4 memReady", memReady, mReady);
      check("R5 arrRd", arrRd, mRd);
      check("R6 arrWr", arrWr, mWr);
      check("R7 accessErr", accessErr, mErr);
      check("R8 R9 blockBusy", blockBusy, mBusy);
      if (arrRd || arrWr) check("R5 R8 arrAddr", arrAddr, mAddr);
      if (arrWr) check("R6 R8 arrWdata", arrWdata, mData);
      check("R10 testSel", testSel, (mReg >> 5) & 7);
      check("R10 testActive", testActive, ((mReg >> 5) & 7) != 0);
    end
  end

  always @(negedge clk) arrAck <= ackOn && (cycleNo % 3 != 2);

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(logic [7:0] a, logic [7:0] d);
    regAddr = a; regWdata = d; regWe = 1;
    cyc();
    regWe = 0; regAddr = CADDR;
  endtask

  task automatic req(bit rd, bit wr, int a, int d);
    memRdReq = rd; memWrReq = wr; memAddr = AW'(a); memWdata = 8'(d);
    cyc();
    memRdReq = 0; memWrReq = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(3);
    regAddr = CADDR;
    #1;
    // R1 reset state
    check("R1 regRdata", regRdata, 0);
    check("R1 regulatorEn", regulatorEn, 0);
    check("R1 memReady", memReady, 0);
    check("R1 cmds", {arrRd, arrWr, blockBusy, accessErr}, 0);
    check("R1 testSel", testSel, 0);
    rstN = 1;
    cyc(2);
    // R2 other address ignored, readback elsewhere is zero
    regWrite(8'h11, 8'h0A);
    regAddr = 8'h11; cyc(); regAddr = CADDR; cyc();
    // R7 request while inactive
    req(1, 0, 3, 0); cyc(2);
    // R3 R4 read-only code 0x02
    regWrite(CADDR, 8'h02);
    req(1, 0, 5, 0);                // too early: R7
    cyc(STARTUP + 2);
    req(1, 0, 7, 0);                // R5
    req(0, 1, 7, 8'h55);            // R6 writes disabled
    cyc(2);
    // R4 switch to the other active code restarts
    regWrite(CADDR, 8'h05);
    cyc(4); req(1, 0, 2, 0); cyc(STARTUP);
    // R6 single write with 0x0A, then R4 rewrite same code keeps ready
    regWrite(CADDR, 8'h0A);
    cyc(STARTUP + 2);
    req(0, 1, 9, 8'hA5);
    regWrite(CADDR, 8'h0A);
    req(1, 0, 9, 0);
    // R6 code 11 refuses writes, same activation code
    regWrite(CADDR, 8'h1A);
    req(0, 1, 4, 8'h33); cyc();
    // R7 both requests together
    req(1, 1, 1, 0); cyc();
    // R8 block write, R7 request while busy
    regWrite(CADDR, 8'h12);
    ackOn = 1;
    req(0, 1, 0, 8'hC3);
    cyc(3); req(1, 0, 1, 0);
    cyc(DEPTH * 2 + 4);
    // R9 abort by deactivation
    req(0, 1, 0, 8'h3C);
    cyc(5);
    regWrite(CADDR, 8'h10);
    cyc(3);
    ackOn = 0;
    // R10 test selector, R3 unrecognised activation code
    regWrite(CADDR, 8'hE2);
    cyc(STARTUP + 2);
    req(1, 0, 6, 0);
    regWrite(CADDR, 8'h07);
    cyc(3);
    regWrite(CADDR, 8'h00);
    cyc(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule